// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a small record of why the system last came out of reset, so that boot software can take a different path after a brownout, a watchdog expiry or a press of the external reset button. Three reset-request lines feed it: one from the low-voltage detector, one from the watchdog and one from the external reset pin. Each line passes through a two-flop synchronizer and is captured on its rising edge. Each captured event updates a set of three sticky flags.

Software reads the record through one 8-bit register on a simple register port. The port has a select, a write strobe, write data and read data. Software clears a flag by writing zero to its bit. A one written to a flag bit leaves it as it is. Two static configuration inputs declare that the voltage detector is switched off or that the reset pin is used as general-purpose I/O. The flag that belongs to a source marked this way reads as zero and cannot be set. The storage is reset only by power-on, so the record outlives the resets it describes.

Top module: `rst_cause_reg`

## Requirements
- R1: After power-on reset, with the detector enabled and the pin enabled, the register reads 0x02: bit 1 is set and all other bits are clear.
- R2: A low-voltage event sets bit 1 and clears bit 4 and bit 2 in the same update.
- R3: A watchdog event sets bit 2 and a pin event sets bit 4. All other flags keep their values.
- R4: A write with select and strobe high computes each flag as its old value ANDed with the matching write-data bit (bit 4, bit 2, bit 1). Writing 1 never sets a flag.
- R5: Bits 7, 6, 5, 3 and 0 always read 0, and writes to them have no effect.
- R6: When the detector-off input is high, bit 1 reads 0. When the pin-as-GPIO input is high, bit 4 reads 0.
- R7: An event from a source marked off has no effect on any flag.
- R8: When an event and a clearing write land in the same update, the event's flag ends up set.
- R9: When a low-voltage event coincides with a watchdog event, a pin event or a write, only bit 1 ends up set.
- R10: A request held high for many cycles is recorded once. Clearing its flag while the request is still high leaves the flag clear.
- R11: Read data is 0 while the select is low, and a strobe without the select changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset; the only reset of the flag storage |
| lv_req | input | 1 | Low-voltage reset request, asynchronous level |
| wd_req | input | 1 | Watchdog reset request, asynchronous level |
| pin_req | input | 1 | External pin reset request, asynchronous level |
| lv_off | input | 1 | High when the voltage detector is disabled |
| pin_gpio | input | 1 | High when the reset pin is used as general-purpose I/O |
| reg_sel | input | 1 | Register address match |
| reg_we | input | 1 | Write strobe, effective only with reg_sel |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the flags |

## Verification
A request raised just before clock edge k passes the first synchronizer flop at k and the second at k+1. The flags change at edge k+2. A write takes effect at the edge where select and strobe are sampled. Read data follows the flags with no register in between. The bench drives every input on the falling edge and reads on the falling edge after the edge where the result is due. To test coincidence, it places the write strobe on exactly the edge at which the synchronized event arrives.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

    localparam int unsigned REG_W     = 8;
    localparam int unsigned NUM_SRC   = 3;
    localparam int unsigned SYNC_LEN  = 2;

    localparam int unsigned BIT_PIN   = 4;
    localparam int unsigned BIT_WD    = 2;
    localparam int unsigned BIT_LV    = 1;

    localparam int unsigned IDX_LV    = 0;
    localparam int unsigned IDX_WD    = 1;
    localparam int unsigned IDX_PIN   = 2;

    localparam logic [REG_W-1:0] USED_MASK =
        REG_W'((1 << BIT_PIN) | (1 << BIT_WD) | (1 << BIT_LV));

    typedef struct packed {
        logic pin;
        logic wd;
        logic lv;
    } cause_t;

    localparam cause_t POR_CAUSE = '{pin: 1'b0, wd: 1'b0, lv: 1'b1};

    function automatic cause_t cause_from_vec(input logic [NUM_SRC-1:0] v);
        cause_t c;
        c.lv  = v[IDX_LV];
        c.wd  = v[IDX_WD];
        c.pin = v[IDX_PIN];
        return c;
    endfunction

    function automatic cause_t cause_from_reg(input logic [REG_W-1:0] d);
        cause_t c;
        c.lv  = d[BIT_LV];
        c.wd  = d[BIT_WD];
        c.pin = d[BIT_PIN];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cause_to_reg(input cause_t c,
                                                      input logic lv_ok,
                                                      input logic pin_ok);
        logic [REG_W-1:0] r;
        r          = '0;
        r[BIT_LV]  = c.lv & lv_ok;
        r[BIT_WD]  = c.wd;
        r[BIT_PIN] = c.pin & pin_ok;
        return r;
    endfunction

endpackage

// File: rtl/rst_cause_sync.sv
module rst_cause_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic rise
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    assign rise = chain[LAST] & ~prev;

    // R10: one captured pulse per rising level
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
    import rst_cause_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t evt,
    input  logic   wr_en,
    input  cause_t wr_keep,
    output cause_t flags
);
    cause_t flags_q;
    cause_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (evt.lv) begin
            flags_d = POR_CAUSE;
        end else begin
            if (wr_en) flags_d = flags_q & wr_keep;
            if (evt.wd)  flags_d.wd  = 1'b1;
            if (evt.pin) flags_d.pin = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= POR_CAUSE;
        else     flags_q <= flags_d;
    end

    assign flags = flags_q;

    a_r2_lv_wipes: assert property (@(posedge clk) disable iff (rst)
        evt.lv |=> (flags.lv && !flags.wd && !flags.pin));

    a_r3_wd_sets: assert property (@(posedge clk) disable iff (rst)
        (evt.wd && !evt.lv) |=> flags.wd);

    a_r3_lv_kept: assert property (@(posedge clk) disable iff (rst)
        (!evt.lv && !wr_en) |=> $stable(flags.lv));

    a_r4_one_never_sets: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.wd) |-> $past(evt.wd));

    a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (evt.pin && !evt.lv && wr_en) |=> flags.pin);

endmodule

// File: rtl/rst_cause_rdmux.sv
module rst_cause_rdmux
    import rst_cause_pkg::*;
(
    input  cause_t           flags,
    input  logic             lv_ok,
    input  logic             pin_ok,
    input  logic             sel,
    output logic [REG_W-1:0] rdata
);
    assign rdata = sel ? cause_to_reg(flags, lv_ok, pin_ok) : '0;

    always_comb begin
        // R5: unused positions never carry a one
        a_r5_unused_zero: assert ((rdata & ~USED_MASK) == '0);
        // R6: an invalid flag is hidden
        a_r6_lv_hidden: assert (lv_ok || !rdata[BIT_LV]);
    end

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_cause_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst,
    input  logic             lv_req,
    input  logic             wd_req,
    input  logic             pin_req,
    input  logic             lv_off,
    input  logic             pin_gpio,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    logic [NUM_SRC-1:0] raw_vec;
    logic [NUM_SRC-1:0] rise_vec;
    logic [NUM_SRC-1:0] ok_vec;
    cause_t             evt;
    cause_t             flags;
    logic               wr_en;

    assign raw_vec[IDX_LV]  = lv_req;
    assign raw_vec[IDX_WD]  = wd_req;
    assign raw_vec[IDX_PIN] = pin_req;

    assign ok_vec[IDX_LV]   = ~lv_off;
    assign ok_vec[IDX_WD]   = 1'b1;
    assign ok_vec[IDX_PIN]  = ~pin_gpio;

    genvar s;
    generate
        for (s = 0; s < NUM_SRC; s++) begin : g_src
            rst_cause_sync #(.STAGES(SYNC_LEN)) u_sync (
                .clk  (clk),
                .rst  (por_rst),
                .raw  (raw_vec[s]),
                .rise (rise_vec[s])
            );
        end
    endgenerate

    assign evt   = cause_from_vec(rise_vec & ok_vec);
    assign wr_en = reg_sel & reg_we;

    rst_cause_flags u_flags (
        .clk     (clk),
        .rst     (por_rst),
        .evt     (evt),
        .wr_en   (wr_en),
        .wr_keep (cause_from_reg(reg_wdata)),
        .flags   (flags)
    );

    rst_cause_rdmux u_rd (
        .flags  (flags),
        .lv_ok  (ok_vec[IDX_LV]),
        .pin_ok (ok_vec[IDX_PIN]),
        .sel    (reg_sel),
        .rdata  (reg_rdata)
    );

    // R7: a disabled detector leaves the pin and watchdog flags alone
    a_r7_off_lv_no_wipe: assert property (@(posedge clk) disable iff (por_rst)
        (lv_off && !rise_vec[IDX_WD] && !rise_vec[IDX_PIN] && !wr_en) |=> $stable(flags));

    // R11: no select, no change from the port
    a_r11_unselected_idle: assert property (@(posedge clk) disable iff (por_rst)
        (!reg_sel && rise_vec == '0) |=> $stable(flags));

endmodule

// File: tb/rst_cause_reg_test.sv
module rst_cause_reg_test;
    logic       clk = 1'b0;
    logic       por_rst;
    logic       lv_req, wd_req, pin_req, lv_off, pin_gpio;
    logic       reg_sel, reg_we;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    rst_cause_reg uut (
        .clk(clk), .por_rst(por_rst), .lv_req(lv_req), .wd_req(wd_req),
        .pin_req(pin_req), .lv_off(lv_off), .pin_gpio(pin_gpio),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    // bit 4 pin, bit 2 watchdog, bit 1 low voltage
    function automatic logic [7:0] enc(input logic p, input logic w, input logic l);
        return {3'b000, p, 1'b0, w, l, 1'b0};
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        reg_sel = 1'b1;
        #1;
        n_chk = n_chk + 1;
        if (reg_rdata !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %02h expected %02h", req, reg_rdata, exp);
        end
        reg_sel = 1'b0;
    endtask

    // pulse chosen requests for one cycle; optional write lands on the
    // same edge where the synchronized events update the flags
    task automatic pulse(input logic l, input logic w, input logic p,
                         input logic do_wr, input logic [7:0] wd);
        lv_req = l; wd_req = w; pin_req = p;
        @(posedge clk); @(negedge clk);
        lv_req = 1'b0; wd_req = 1'b0; pin_req = 1'b0;
        @(posedge clk); @(negedge clk);
        if (do_wr) begin reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = wd; end
        @(posedge clk); @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d, input logic sel);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00;
    endtask

    initial begin
        por_rst = 1'b1; lv_req = 0; wd_req = 0; pin_req = 0;
        lv_off = 0; pin_gpio = 0; reg_sel = 0; reg_we = 0; reg_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); por_rst = 1'b0;
        check("R1", 8'h02);
        reg_sel = 1'b0; #1;
        n_chk = n_chk + 1;
        if (reg_rdata !== 8'h00) begin
            n_fail = n_fail + 1;
            $display("FAIL R11: actual %02h expected 00", reg_rdata);
        end

        // sweep: start state x event set x optional clear-all write
        for (int st = 0; st < 8; st++) begin
            for (int ev = 0; ev < 8; ev++) begin
                for (int cw = 0; cw < 2; cw++) begin
                    logic sp, sw, sl, ep, ew, el, xp, xw, xl;
                    sl = st[0]; sw = st[1]; sp = st[2];
                    el = ev[0]; ew = ev[1]; ep = ev[2];
                    if (sl) pulse(1, 0, 0, 0, 8'h00);
                    else    wr(8'h00, 1'b1);
                    if (sw) pulse(0, 1, 0, 0, 8'h00);
                    if (sp) pulse(0, 0, 1, 0, 8'h00);
                    pulse(el, ew, ep, cw[0], 8'h00);
                    if (el) begin
                        xl = 1; xw = 0; xp = 0;
                    end else begin
                        xl = sl & ~cw[0]; xw = (sw & ~cw[0]) | ew; xp = (sp & ~cw[0]) | ep;
                    end
                    check(el ? (cw[0] ? "R9" : "R2") : (cw[0] ? "R8" : "R3"), enc(xp, xw, xl));
                end
            end
        end

        // R4 per-bit clear and write-one has no effect; R5 unused bits
        pulse(1, 0, 0, 0, 8'h00); pulse(0, 1, 1, 0, 8'h00);
        wr(8'hFF, 1'b1);
        check("R4", enc(1, 1, 1));
        wr(8'hEF, 1'b1);
        check("R4", enc(0, 1, 1));
        wr(8'h00, 1'b1); wr(8'hFF, 1'b1);
        check("R5", 8'h00);

        // R11 strobe without select
        pulse(0, 1, 0, 0, 8'h00);
        wr(8'h00, 1'b0);
        check("R11", enc(0, 1, 0));

        // R6 masking and R7 disabled sources
        pulse(0, 0, 1, 0, 8'h00); pulse(1, 0, 0, 0, 8'h00); pulse(0, 0, 1, 0, 8'h00);
        lv_off = 1'b1;
        check("R6", enc(1, 0, 0));
        pulse(1, 0, 0, 0, 8'h00);
        check("R7", enc(1, 0, 0));
        lv_off = 1'b0;
        check("R7", enc(1, 0, 1));
        pin_gpio = 1'b1;
        check("R6", enc(0, 0, 1));
        wr(8'h00, 1'b1);
        pulse(0, 0, 1, 0, 8'h00);
        pin_gpio = 1'b0;
        check("R7", 8'h00);

        // R10 held request recorded once
        wd_req = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R10", enc(0, 1, 0));
        wr(8'h00, 1'b1);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R10", 8'h00);
        wd_req = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R10", 8'h00);

        finish_run();
    end
endmodule